// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns one operand specifier of a two-address instruction set into everything the execute stage needs to reach that operand. A specifier is six bits: a three-bit mode in bits 5..3 and a three-bit register field in bits 2..0. It arrives with the operand size, up to two 16-bit extension words taken from the instruction stream, the value of the named address register, the value of an index register, and the address of the instruction word. The block returns the effective address and the updated address-register value with its write enable. It also returns the number of extension words used and the address of the next instruction. The register file and the memory port sit outside the block. The index register is named on an output so the register file can return its value in the same cycle.

Requests enter on a valid/ready handshake and results leave on another, through one output register. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle. A result is presented with `out_valid` and stays unchanged until `out_ready` is seen high. Back-pressure therefore stalls the request side only when the output register holds an undelivered result.

Top module: `ea_gen`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every result output holds its value on the next cycle.
- R3: Modes 000 and 001 (register direct) give `ea_vld`=0, `ea`=0, `ext_cnt`=0 and `an_wr`=0. When `an_wr` is 0, `an_next` equals `areg` in every mode.
- R4: Mode 010 gives `ea`=`areg`. Mode 011 gives `ea`=`areg` and `an_next`=`areg`+step with `an_wr`=1. The step is 1, 2 or 4 for size codes 00, 01 or 10, and 4 for size code 11.
- R5: Mode 100 gives `ea`=`an_next`=`areg`−step, with `an_wr`=1.
- R6: Mode 101 gives `ea`=`areg` plus sign-extended `ext0`, with `ext_cnt`=1 and `areg` left unchanged.
- R7: Mode 110 decodes `ext0` as follows. Bit 15 selects address (1) or data (0) index. Bits 14..12 give the index number. Bit 11 selects a longword (1) or word (0) index. Bits 10..9 give the scale code (00→×1, 01→×2, 10→×4). Bits 7..0 give a signed displacement. `ea` = `areg` + displacement + index×scale, and `ext_cnt`=1. Example: `areg`=0x782C, index 4, `ext0`=0x1C24 gives 0x7860.
- R8: In mode 110 with a word index, bits 15..0 of `idx_val` are sign-extended before scaling.
- R9: Mode 111 with register field 000 (absolute short) gives `ea` = zero-extended `ext0` and `ext_cnt`=1. The operand is illegal when `ext0` bit 15 is set.
- R10: Mode 111 with register field 001 (absolute long) gives `ea`={`ext0`,`ext1`} and `ext_cnt`=2.
- R11: Mode 111 with register field 100 (immediate) gives `ea_vld`=0. `ext_cnt` is 2 for size code 10 or 11 and 1 for size 00 or 01.
- R12: `pc_next` = `pc` + 2 + 2×`ext_cnt`, for example 0x8100 → 0x8106 for absolute long.
- R13: `illegal` is raised for mode 111 with register field 010, 011, 101, 110 or 111 (`ext_cnt`=0), and for mode 110 with scale code 11. An illegal result has `ea_vld`=0, `ea`=0 and `an_wr`=0.
- R14: `idx_rsel` equals {`ext0`[15], `ext0`[14:12]}, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| spec | input | 6 | Mode (5..3) and register field (2..0) |
| size | input | 2 | Operand size: 00 byte, 01 word, 10/11 longword |
| ext0 | input | 16 | First extension word |
| ext1 | input | 16 | Second extension word |
| areg | input | 32 | Value of the address register named by spec |
| idx_val | input | 32 | Value of the register named by idx_rsel |
| pc | input | 32 | Address of the instruction word |
| idx_rsel | output | 4 | Index register selector taken from ext0 |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumed when high with out_valid |
| ea | output | 32 | Effective address, 0 when ea_vld is 0 |
| ea_vld | output | 1 | Operand is in memory at ea |
| an_next | output | 32 | New address register value |
| an_wr | output | 1 | Write an_next back to the register |
| ext_cnt | output | 2 | Extension words consumed |
| pc_next | output | 32 | Address of the following instruction |
| illegal | output | 1 | Operand specifier is not allowed |

## Verification
Accepting a new request and handing over the held result can happen on the same edge. The bench provokes this by toggling `out_ready` at random while requests arrive back to back. It then compares every delivered result, in order, against a queue of values its own model computed at acceptance. A lost, duplicated or overwritten result shows up as a mismatch. A second collision happens inside the result: in the pre-decrement and post-increment modes, the address and the register write-back are formed in the same cycle. The directed cases check both values against the size step.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int ADDR_W = 32;
  localparam int EXT_W  = 16;

  typedef enum logic [3:0] {
    K_REG, K_IND, K_POST, K_PRE, K_DISP, K_IDX, K_ABSW, K_ABSL, K_IMM, K_BAD
  } ea_kind_t;
endpackage

// File: rtl/ea_mode_dec.sv
module ea_mode_dec
  import ea_pkg::*;
(
  input  logic [2:0] mode,
  input  logic [2:0] rfield,
  input  logic [1:0] size,
  input  logic       abs_msb,
  input  logic [1:0] scale,
  output ea_kind_t   kind,
  output logic [1:0] ext_cnt,
  output logic       mem,
  output logic       illegal
);
  always_comb begin
    kind    = K_REG;
    ext_cnt = 2'd0;
    mem     = 1'b0;
    illegal = 1'b0;
    unique case (mode)
      3'b000, 3'b001: kind = K_REG;
      3'b010: begin kind = K_IND;  mem = 1'b1; end
      3'b011: begin kind = K_POST; mem = 1'b1; end
      3'b100: begin kind = K_PRE;  mem = 1'b1; end
      3'b101: begin kind = K_DISP; mem = 1'b1; ext_cnt = 2'd1; end
      3'b110: begin
        kind = K_IDX; mem = 1'b1; ext_cnt = 2'd1;
        illegal = (scale == 2'b11);
      end
      default: begin
        unique case (rfield)
          3'b000: begin
            kind = K_ABSW; mem = 1'b1; ext_cnt = 2'd1; illegal = abs_msb;
          end
          3'b001: begin kind = K_ABSL; mem = 1'b1; ext_cnt = 2'd2; end
          3'b100: begin kind = K_IMM; ext_cnt = size[1] ? 2'd2 : 2'd1; end
          default: begin kind = K_BAD; illegal = 1'b1; end
        endcase
      end
    endcase
  end
endmodule

// File: rtl/ea_idx_unit.sv
module ea_idx_unit #(
  parameter int AW = 32,
  parameter int HW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0] idx_val,
  input  logic          long_idx,
  input  logic [1:0]    scale,
  input  logic [DW-1:0] disp,
  output logic [AW-1:0] term
);
  logic [AW-1:0] idx_ext;
  logic [AW-1:0] idx_scaled;
  logic [AW-1:0] disp_ext;

  always_comb begin
    idx_ext    = long_idx ? idx_val : {{(AW-HW){idx_val[HW-1]}}, idx_val[HW-1:0]};
    idx_scaled = idx_ext << scale;
    disp_ext   = {{(AW-DW){disp[DW-1]}}, disp};
    term       = idx_scaled + disp_ext;
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int EW = EXT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [5:0]    spec,
  input  logic [1:0]    size,
  input  logic [EW-1:0] ext0,
  input  logic [EW-1:0] ext1,
  input  logic [AW-1:0] areg,
  input  logic [AW-1:0] idx_val,
  input  logic [AW-1:0] pc,
  output logic [3:0]    idx_rsel,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] ea,
  output logic          ea_vld,
  output logic [AW-1:0] an_next,
  output logic          an_wr,
  output logic [1:0]    ext_cnt,
  output logic [AW-1:0] pc_next,
  output logic          illegal
);
  localparam int IDX_DW = 8;
  localparam int HI_W   = AW - EW;

  ea_kind_t      kind;
  logic [1:0]    c_ext;
  logic          c_mem, c_ill;
  logic [AW-1:0] idx_term, step, c_ea, c_anx, c_pcn;
  logic          c_wr;

  ea_mode_dec u_dec (
    .mode(spec[5:3]), .rfield(spec[2:0]), .size(size),
    .abs_msb(ext0[EW-1]), .scale(ext0[10:9]),
    .kind(kind), .ext_cnt(c_ext), .mem(c_mem), .illegal(c_ill)
  );

  ea_idx_unit #(.AW(AW), .HW(16), .DW(IDX_DW)) u_idx (
    .idx_val(idx_val), .long_idx(ext0[11]), .scale(ext0[10:9]),
    .disp(ext0[IDX_DW-1:0]), .term(idx_term)
  );

  assign idx_rsel = {ext0[15], ext0[14:12]};

  always_comb begin
    unique case (size)
      2'b00:   step = AW'(1);
      2'b01:   step = AW'(2);
      default: step = AW'(4);
    endcase
    c_ea  = '0;
    c_anx = areg;
    c_wr  = 1'b0;
    unique case (kind)
      K_IND:  c_ea = areg;
      K_POST: begin c_ea = areg; c_anx = areg + step; c_wr = 1'b1; end
      K_PRE:  begin c_ea = areg - step; c_anx = areg - step; c_wr = 1'b1; end
      K_DISP: c_ea = areg + {{HI_W{ext0[EW-1]}}, ext0};
      K_IDX:  c_ea = areg + idx_term;
      K_ABSW: c_ea = {{HI_W{1'b0}}, ext0};
      K_ABSL: c_ea = {ext0, ext1};
      default: c_ea = '0;
    endcase
    if (c_ill || !c_mem) c_ea = '0;
    if (c_ill) begin
      c_wr  = 1'b0;
      c_anx = areg;
    end
    c_pcn = pc + AW'(2) + AW'({c_ext, 1'b0});
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ea        <= '0;
      ea_vld    <= 1'b0;
      an_next   <= '0;
      an_wr     <= 1'b0;
      ext_cnt   <= 2'd0;
      pc_next   <= '0;
      illegal   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        ea      <= c_ea;
        ea_vld  <= c_mem && !c_ill;
        an_next <= c_anx;
        an_wr   <= c_wr;
        ext_cnt <= c_ext;
        pc_next <= c_pcn;
        illegal <= c_ill;
      end
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] ea,
  input logic          ea_vld,
  input logic [AW-1:0] an_next,
  input logic          an_wr,
  input logic [1:0]    ext_cnt,
  input logic [AW-1:0] pc_next,
  input logic          illegal
);
  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(ea) && $stable(an_next)
      && $stable(pc_next) && $stable(ext_cnt) && $stable(illegal));

  p_stall_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && (!out_valid || out_ready) |=> !out_valid);

  p_wb_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && an_wr |-> (an_next == ea) || (an_next - ea == AW'(1))
      || (an_next - ea == AW'(2)) || (an_next - ea == AW'(4)));

  p_ill_gate_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && illegal |-> !an_wr && !ea_vld && ea == '0);

  p_ext_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ext_cnt != 2'd3);

  p_noea_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !ea_vld |-> ea == '0);
endmodule

bind ea_gen ea_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .ea(ea), .ea_vld(ea_vld),
  .an_next(an_next), .an_wr(an_wr), .ext_cnt(ext_cnt), .pc_next(pc_next),
  .illegal(illegal)
);

// File: tb/test_ea_gen.sv
module test_ea_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  spec = '0;
  logic [1:0]  size = '0;
  logic [15:0] ext0 = '0, ext1 = '0;
  logic [31:0] areg = '0, idx_val = '0, pc = '0;
  logic [3:0]  idx_rsel;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] ea, an_next, pc_next;
  logic        ea_vld, an_wr, illegal;
  logic [1:0]  ext_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit rand_rdy = 1'b0;

  typedef struct {
    logic [31:0] ea;
    logic        vld;
    logic [31:0] anx;
    logic        wr;
    logic [1:0]  n;
    logic [31:0] pcn;
    logic        ill;
    string       req;
  } exp_t;

  exp_t expq[$];

  always #2 clk = ~clk;

  ea_gen i_ea_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .spec(spec), .size(size), .ext0(ext0), .ext1(ext1), .areg(areg),
    .idx_val(idx_val), .pc(pc), .idx_rsel(idx_rsel), .out_valid(out_valid),
    .out_ready(out_ready), .ea(ea), .ea_vld(ea_vld), .an_next(an_next),
    .an_wr(an_wr), .ext_cnt(ext_cnt), .pc_next(pc_next), .illegal(illegal)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [5:0] s, input logic [1:0] z,
      input logic [15:0] e0, input logic [15:0] e1, input logic [31:0] a,
      input logic [31:0] x, input logic [31:0] p);
    exp_t r;
    logic [31:0] st, ix;
    st = (z == 2'd0) ? 32'd1 : (z == 2'd1) ? 32'd2 : 32'd4;
    r.ea = 0; r.vld = 0; r.anx = a; r.wr = 0; r.n = 0; r.ill = 0; r.req = "R3";
    case (s[5:3])
      3'd2: begin r.ea = a; r.vld = 1; r.req = "R4"; end
      3'd3: begin r.ea = a; r.vld = 1; r.anx = a + st; r.wr = 1; r.req = "R4"; end
      3'd4: begin r.ea = a - st; r.vld = 1; r.anx = a - st; r.wr = 1; r.req = "R5"; end
      3'd5: begin r.ea = a + 32'(signed'(e0)); r.vld = 1; r.n = 1; r.req = "R6"; end
      3'd6: begin
        ix = e0[11] ? x : 32'(signed'(x[15:0]));
        r.n = 1; r.req = e0[11] ? "R7" : "R8";
        if (e0[10:9] == 2'b11) begin r.ill = 1; r.req = "R13"; end
        else begin
          r.vld = 1;
          r.ea = a + 32'(signed'(e0[7:0])) + ix * (32'd1 << e0[10:9]);
        end
      end
      3'd7: begin
        if (s[2:0] == 3'd0) begin
          r.n = 1; r.req = "R9";
          if (e0[15]) r.ill = 1; else begin r.vld = 1; r.ea = {16'h0, e0}; end
        end else if (s[2:0] == 3'd1) begin
          r.n = 2; r.vld = 1; r.ea = {e0, e1}; r.req = "R10";
        end else if (s[2:0] == 3'd4) begin
          r.n = z[1] ? 2 : 1; r.req = "R11";
        end else begin r.ill = 1; r.req = "R13"; end
      end
      default: ;
    endcase
    r.pcn = p + 32'd2 + 32'd2 * 32'(r.n);
    return r;
  endfunction

  task automatic send(input logic [5:0] s, input logic [1:0] z,
      input logic [15:0] e0, input logic [15:0] e1, input logic [31:0] a,
      input logic [31:0] x, input logic [31:0] p);
    spec = s; size = z; ext0 = e0; ext1 = e1; areg = a; idx_val = x; pc = p;
    in_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) begin
        chk(idx_rsel == {e0[15], e0[14:12]}, "R14", 32'(idx_rsel),
            32'({e0[15], e0[14:12]}));
        expq.push_back(model(s, z, e0, e1, a, x, p));
        @(posedge clk); #1;
        break;
      end
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
  endtask

  // Output monitor: compares delivered results in order, checks stall hold.
  initial begin
    bit stalled = 1'b0;
    logic [31:0] held_ea = '0, held_pc = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (stalled) begin
          chk(out_valid && ea == held_ea && pc_next == held_pc, "R2 hold",
              ea, held_ea);
        end
        chk(in_ready == (!out_valid || out_ready), "R2 ready", 32'(in_ready),
            32'(!out_valid || out_ready));
        if (out_valid && out_ready) begin
          exp_t e;
          if (expq.size() == 0) chk(1'b0, "R2 extra", 32'd1, 32'd0);
          else begin
            e = expq.pop_front();
            chk(ea == e.ea && ea_vld == e.vld, {e.req, " ea"}, ea, e.ea);
            chk(an_next == e.anx && an_wr == e.wr, {e.req, " an"}, an_next, e.anx);
            chk(ext_cnt == e.n && pc_next == e.pcn, {e.req, " R12 pc"}, pc_next, e.pcn);
            chk(illegal == e.ill, {e.req, " illegal"}, 32'(illegal), 32'(e.ill));
          end
        end
        stalled = out_valid && !out_ready;
        held_ea = ea; held_pc = pc_next;
      end
    end
  end

  // Random back-pressure
  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = rand_rdy ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0 pending", expq.size());
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R1 reset", 32'(out_valid), 32'd0);
    @(posedge clk); #1;

    // Directed corner cases
    send(6'o02, 2'd2, 16'h0, 16'h0, 32'h12345678, 32'h0, 32'h1000);   // R3 data direct
    send(6'o13, 2'd0, 16'h0, 16'h0, 32'h7000, 32'h0, 32'h1000);       // R3 addr direct
    send(6'o21, 2'd1, 16'h0, 16'h0, 32'h7060, 32'h0, 32'h1000);       // R4 indirect
    send(6'o30, 2'd0, 16'h0, 16'h0, 32'h7060, 32'h0, 32'h1000);       // R4 post byte
    send(6'o30, 2'd1, 16'h0, 16'h0, 32'h7060, 32'h0, 32'h1000);       // R4 post word
    send(6'o30, 2'd3, 16'h0, 16'h0, 32'h7060, 32'h0, 32'h1000);       // R4 post size 11
    send(6'o40, 2'd2, 16'h0, 16'h0, 32'h7064, 32'h0, 32'h1000);       // R5 pre long
    send(6'o40, 2'd0, 16'h0, 16'h0, 32'h0, 32'h0, 32'h1000);          // R5 wrap
    send(6'o50, 2'd2, 16'h0024, 16'h0, 32'h703C, 32'h0, 32'h1000);    // R6 positive
    send(6'o50, 2'd2, 16'hFFF0, 16'h0, 32'h703C, 32'h0, 32'h1000);    // R6 negative
    send(6'o60, 2'd2, 16'h1C24, 16'h0, 32'h782C, 32'h4, 32'h1000);    // R7 example 0x7860
    send(6'o60, 2'd2, 16'h1CFC, 16'h0, 32'h703C, 32'hFFFFFF00, 32'h1000); // R7 negative
    send(6'o60, 2'd2, 16'h9224, 16'h0, 32'h1000, 32'h0001FFFE, 32'h1000); // R8 word idx
    send(6'o60, 2'd2, 16'h0624, 16'h0, 32'h1000, 32'h4, 32'h1000);    // R13 scale 11
    send(6'o70, 2'd1, 16'h7060, 16'h0, 32'h0, 32'h0, 32'h1000);       // R9 short
    send(6'o70, 2'd1, 16'h8000, 16'h0, 32'h0, 32'h0, 32'h1000);       // R9 short illegal
    send(6'o71, 2'd2, 16'h0001, 16'h8060, 32'h0, 32'h0, 32'h8100);    // R10, R12 0x8106
    send(6'o74, 2'd0, 16'h0012, 16'h0, 32'h0, 32'h0, 32'h2000);       // R11 byte
    send(6'o74, 2'd2, 16'h0012, 16'h3456, 32'h0, 32'h0, 32'h2000);    // R11 long
    send(6'o72, 2'd2, 16'h0, 16'h0, 32'h4444, 32'h0, 32'h2000);       // R13 reserved
    send(6'o77, 2'd2, 16'h0, 16'h0, 32'h4444, 32'h0, 32'h2000);       // R13 reserved

    // Random phase with back-pressure
    rand_rdy = 1'b1;
    for (int i = 0; i < 600; i++) begin
      send(6'($urandom), 2'($urandom), 16'($urandom), 16'($urandom),
           $urandom, $urandom, $urandom & 32'hFFFFFFFE);
      if (($urandom % 4) == 0) begin
        @(posedge clk); #1;
      end
    end
    rand_rdy = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(expq.size() == 0 && !out_valid, "R2 drain", 32'(expq.size()), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule